// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a peripheral clock into the two timing strobes that a UART's shift logic needs. The first is an oversampling tick, which the receiver uses to sample the line several times per bit. The second is a bit tick, which marks each bit boundary. The rate comes from a fixed-point divisor. Its upper 12 bits are an integer mantissa and its lower 4 bits are a fraction. A mode input picks 16 or 8 oversamples per bit.

The interval between oversample ticks is normally the mantissa in clocks. A phase accumulator adds the fraction once per interval. Whenever that accumulator carries, the interval is stretched by one clock, so the long-run average interval equals the divisor exactly. In 8x mode the fraction is only three bits wide. Its top bit is treated as zero.

Deasserting enable, or changing the effective divisor or the mode, returns every counter to its start. The next bit period then begins from a clean phase.

Top module: `baud_tick_gen`

## Requirements
- R1: `ovsTick` pulses for one clock. For mantissa M (`divisor[15:4]`) and effective fraction F over denominator D, each oversample interval lasts M or M+1 clocks, and the long-run average is M + F/D clocks.
- R2: With `overEight`=0 (16x), F is `divisor[3:0]` and D is 16. `bitTick` fires on every 16th `ovsTick`. For example, M=1, F=0 gives a 16-clock bit period, and M=2, F=8 gives a 40-clock bit period.
- R3: With `overEight`=1 (8x), F is `divisor[2:0]` and D is 8. `bitTick` fires on every 8th `ovsTick`. For example, M=1 gives 8 clocks, M=2 gives 16 clocks, and M=1, F=4 gives 12 clocks.
- R4: In 8x mode, `divisor[3]` is ignored. It does not change tick timing, and writing it does not restart the counters.
- R5: When M is 0, both `ovsTick` and `bitTick` stay low.
- R6: While `enable` is low, both ticks stay low. After `enable` rises, the first `bitTick` appears N·L rising edges later, where L is the interval length and N is the number of oversamples per bit.
- R7: A change of mantissa, effective fraction or mode restarts the counters. With an integer divisor, the first `bitTick` appears N·M rising edges after the change.
- R8: `bitTick` is never high unless `ovsTick` is high in the same cycle.
- R9: During and directly after reset, both ticks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high |
| divisor | input | 16 | Mantissa in [15:4], fraction in [3:0] |
| overEight | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| ovsTick | output | 1 | One-clock oversample strobe |
| bitTick | output | 1 | One-clock bit-boundary strobe |

## Verification
The bench measures the bit period and counts oversample ticks per bit for several divisors:
- Integer divisors in both modes separate the two oversampling ratios.
- A half fraction in each mode shows whether the carry stretches the right intervals and whether the fraction is scaled by 16 or by 8.
- A divisor with only the top fraction bit set in 8x mode, and a toggle of that bit in mid-stream, show that the bit is truly ignored.
- A zero mantissa, an enable drop and a mid-stream divisor write separate gating from restart behaviour.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef struct packed {
    logic clear;
    logic run;
  } baud_strobe_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_tick_pkg::*;
#(
  parameter int MantW = 12,
  parameter int FracW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [MantW+FracW-1:0] divisor,
  input  logic                   overEight,
  output baud_strobe_t           strobe
);
  localparam int DivW = MantW + FracW;

  logic [DivW-1:0] effDiv;
  logic [DivW-1:0] prevDiv;
  logic            prevMode;
  logic            prevEn;
  logic            changed;
  logic            mantZero;

  // In 8x mode the top fraction bit is masked out, so writing it is no change.
  always_comb begin
    effDiv = divisor;
    if (overEight) effDiv[FracW-1] = 1'b0;
  end

  assign changed  = (effDiv != prevDiv) || (overEight != prevMode);
  assign mantZero = (divisor[DivW-1:FracW] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevDiv  <= '0;
      prevMode <= 1'b0;
      prevEn   <= 1'b0;
    end else begin
      prevDiv  <= effDiv;
      prevMode <= overEight;
      prevEn   <= enable;
    end
  end

  always_comb begin
    strobe.clear = !enable || !prevEn || changed;
    strobe.run   = !strobe.clear && !mantZero;
  end
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_tick_pkg::*;
#(
  parameter int MantW = 12,
  parameter int FracW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [MantW+FracW-1:0] divisor,
  input  logic                   overEight,
  input  baud_strobe_t           strobe,
  output logic                   ovsTick,
  output logic                   bitTick
);
  localparam int DivW = MantW + FracW;
  localparam int CntW = MantW + 1;
  localparam logic [FracW-1:0] LastHi = FracW'((1 << FracW) - 1);
  localparam logic [FracW-1:0] LastLo = FracW'((1 << (FracW - 1)) - 1);

  logic [MantW-1:0] mant;
  logic [FracW-1:0] fracEff;
  logic [FracW-1:0] acc;
  logic [FracW-1:0] accNext;
  logic [FracW:0]   sumWide;
  logic             carry;
  logic [CntW-1:0]  len;
  logic [CntW-1:0]  cnt;
  logic             cntEnd;
  logic [FracW-1:0] osCnt;
  logic [FracW-1:0] osLast;

  assign mant = divisor[DivW-1:FracW];

  always_comb begin
    if (overEight) begin
      fracEff = {1'b0, divisor[FracW-2:0]};
      osLast  = LastLo;
    end else begin
      fracEff = divisor[FracW-1:0];
      osLast  = LastHi;
    end
  end

  // Add the fraction once per interval; the carry out stretches this interval.
  assign sumWide = {1'b0, acc} + {1'b0, fracEff};

  always_comb begin
    if (overEight) begin
      carry   = sumWide[FracW-1];
      accNext = {1'b0, sumWide[FracW-2:0]};
    end else begin
      carry   = sumWide[FracW];
      accNext = sumWide[FracW-1:0];
    end
  end

  assign len     = {1'b0, mant} + CntW'(carry);
  assign cntEnd  = (cnt == len - CntW'(1));
  assign ovsTick = strobe.run && cntEnd;
  assign bitTick = ovsTick && (osCnt == osLast);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      cnt   <= '0;
      acc   <= '0;
      osCnt <= '0;
    end else if (strobe.run) begin
      if (cntEnd) begin
        cnt   <= '0;
        acc   <= accNext;
        osCnt <= (osCnt == osLast) ? '0 : osCnt + FracW'(1);
      end else begin
        cnt <= cnt + CntW'(1);
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int MantW = 12,
  parameter int FracW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [MantW+FracW-1:0] divisor,
  input  logic                   overEight,
  output logic                   ovsTick,
  output logic                   bitTick
);
  baud_strobe_t strobe;

  baud_ctrl #(.MantW(MantW), .FracW(FracW)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
    .overEight(overEight), .strobe(strobe)
  );

  baud_datapath #(.MantW(MantW), .FracW(FracW)) dp (
    .clk(clk), .rstN(rstN), .divisor(divisor), .overEight(overEight),
    .strobe(strobe), .ovsTick(ovsTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int MantW = 12,
  parameter int FracW = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   enable,
  input logic [MantW+FracW-1:0] divisor,
  input logic                   overEight,
  input logic                   ovsTick,
  input logic                   bitTick
);
  localparam int DivW = MantW + FracW;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!ovsTick && !bitTick)); // R6

  AST_ZERO_MANT: assert property (@(posedge clk) disable iff (!rstN)
    (divisor[DivW-1:FracW] == '0) |-> (!ovsTick && !bitTick)); // R5

  AST_BIT_WITH_OVS: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovsTick); // R8

  AST_OVS_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && divisor[DivW-1:FracW] > 1) |=> !ovsTick); // R1

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(divisor[DivW-1:FracW]) || !$stable(overEight)) |-> !ovsTick); // R7
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.MantW(MantW), .FracW(FracW)) chk (
  .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
  .overEight(overEight), .ovsTick(ovsTick), .bitTick(bitTick)
);

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divisor = '0;
  logic        overEight = 1'b0;
  logic        ovsTick;
  logic        bitTick;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
    .overEight(overEight), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count cycles (and oversample ticks) until the next bitTick.
  task automatic waitBit(output int cyc, output int ovs);
    cyc = 0; ovs = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cyc++;
      if (ovsTick) ovs++;
      if (bitTick) break;
    end
  endtask

  task automatic runCfg(input string req, input int mant, input int frac,
                        input bit mode, input int expPeriod, input int expOvs);
    int cyc, ovs;
    @(negedge clk);
    divisor   = 16'((mant << 4) | frac);
    overEight = mode;
    enable    = 1'b1;
    waitBit(cyc, ovs);
    check({req, " first bit"}, cyc, expPeriod);
    check({req, " ovs per bit"}, ovs, expOvs);
    waitBit(cyc, ovs);
    check({req, " period"}, cyc, expPeriod);
  endtask

  task automatic testReset();
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ovsTick || bitTick) seen++;
    end
    check("R9 ticks during reset", seen, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 ticks after reset", int'(ovsTick) + int'(bitTick), 0);
  endtask

  task automatic testZeroMant();
    int seen = 0;
    @(negedge clk);
    divisor = 16'h0007;
    overEight = 1'b0;
    enable = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ovsTick || bitTick) seen++;
    end
    check("R5 zero mantissa", seen, 0);
  endtask

  task automatic testEnable();
    int cyc, ovs;
    @(negedge clk);
    divisor = 16'h0020; overEight = 1'b1; enable = 1'b1;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    #1;
    check("R6 low enable", int'(ovsTick) + int'(bitTick), 0);
    @(negedge clk);
    enable = 1'b1;
    waitBit(cyc, ovs);
    check("R6 restart after enable", cyc, 16);
  endtask

  task automatic testRewrite();
    int cyc, ovs;
    @(negedge clk);
    divisor = 16'h0020; overEight = 1'b1; enable = 1'b1;
    repeat (7) @(negedge clk);
    divisor = 16'h0010;
    waitBit(cyc, ovs);
    check("R7 restart after write", cyc, 8);
  endtask

  task automatic testBit3Toggle();
    int cyc = 0, ovs;
    @(negedge clk);
    divisor = 16'h0030; overEight = 1'b1; enable = 1'b1;
    waitBit(cyc, ovs);
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) divisor[3] = 1'b1;
      if (bitTick) break;
    end
    check("R4 bit3 toggle no restart", cyc, 24);
  endtask

  initial begin
    testReset();
    runCfg("R3 8x M=1", 1, 0, 1'b1, 8, 8);
    runCfg("R3 8x M=2", 2, 0, 1'b1, 16, 8);
    runCfg("R2 16x M=1", 1, 0, 1'b0, 16, 16);
    runCfg("R2 R1 16x M=2.5", 2, 8, 1'b0, 40, 16);
    runCfg("R3 R1 8x M=1.5", 1, 4, 1'b1, 12, 8);
    runCfg("R4 8x bit3 set", 3, 8, 1'b1, 24, 8);
    testZeroMant();
    testEnable();
    testRewrite();
    testBit3Toggle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule